// File: doc/BRIEF.md
# Real-Time Clock Control and Status Register Bank

This block holds the four byte-wide control and status registers of a real-time clock and sits on a simple synchronous register bus. The bus has an address, write data, a write strobe, a read strobe and registered read data. Software uses the registers to pick the periodic rate, turn the oscillator and the divider chain on or off, and choose the data formats. It also enables the interrupt sources and reads or acknowledges the interrupt flags.

A three-bit mode field in register A is decoded into an oscillator enable and a divider enable. When the divider comes on, the block counts half a second of input clocks before it issues the first one-second update pulse. After that it issues one pulse every second. An update-in-progress bit rises a fixed number of cycles before each pulse, so software can tell when the time registers are about to change. The same bit is held low while the transfer-inhibit bit is set. Periodic and alarm events arrive as single-cycle pulses from logic outside this block. The update pulse is produced here. All three sources are latched as flags, masked by their enables and combined into one interrupt request.

Top module: `rtc_ctrl_regs`

## Requirements
- R1: The registers decode at byte addresses 0x0A (A), 0x0B (B), 0x0C (C) and 0x0D (D), and any of them can be read at any time. Any other address reads 0x00 and ignores writes. `bus_rdata` is loaded on the clock edge where `bus_re` is high and holds its value until the next read.
- R2: Register A layout:
  - bit 7 is the update-in-progress bit, and writes to it are ignored;
  - bits 6:4 are the mode field;
  - bits 3:0 are the rate select, and `rate_sel` always shows them.
  
  Mode decode:
  - 010 and 011 set both `osc_en` and `div_en`;
  - 110 and 111 set only `osc_en`;
  - 000, 001, 100 and 101 clear both.
- R3: The first `update_pulse` comes CLKS_PER_SEC/2 cycles after the edge that enables the divider. Later pulses follow every CLKS_PER_SEC cycles. No pulse occurs while `div_en` is low.
- R4: The update-in-progress bit (A bit 7 and the `uip` output) is high for exactly LEAD_CYCLES cycles, the last of which is the pulse cycle, and is low at every other time.
- R5: The update-in-progress bit is held low whenever register B bit 7 (transfer inhibit) is 1.
- R6: Register B is fully read/write, with this layout:

  | Bit | Meaning | Output |
  |---|---|---|
  | 7 | transfer inhibit | `update_xfer_inhibit` |
  | 6 | periodic enable | |
  | 5 | alarm enable | |
  | 4 | update enable | |
  | 3 | square-wave enable | `sqw_en` |
  | 2 | binary format | `fmt_bin` |
  | 1 | 24-hour format | `fmt_24h` |
  | 0 | daylight-saving enable | `dst_en` |
- R7: Reset does the following:
  - it clears B bits 6:3 and the periodic, alarm and update flags;
  - it does not change A bits 6:0, B bits 7, 2, 1 and 0, or register C bit 2.
- R8: Register C layout:
  - bit 7 is the combined interrupt flag;
  - bit 6 is the periodic flag, bit 5 the alarm flag and bit 4 the update flag;
  - bit 2 is the 32 kHz enable;
  - bits 3, 1 and 0 read 0.
  
  Writes to C take effect only when the mode field is 011. Such a write loads bits 6:4 and bit 2.
- R9: `periodic_evt` sets the periodic flag, `alarm_evt` sets the alarm flag and `update_pulse` sets the update flag. Each flag is set whatever its enable bit holds.
- R10: C bit 7 and `irq` are 1 exactly when some flag is set together with its enable bit (periodic with B6, alarm with B5, update with B4).
- R11: A read of register C returns the flags as they were before the read and then clears all three. An event in the same cycle as the read sets its flag anyway.
- R12: Register D bit 7 reads `vrt_in`, its other bits read 0, and writes to D have no effect.
- R13: `sq32k_en` is 1 only when register C bit 2 is 1 and the mode field is 011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| periodic_evt | input | 1 | One-cycle periodic event from the rate divider |
| alarm_evt | input | 1 | One-cycle alarm match event |
| vrt_in | input | 1 | Backup supply valid status |
| osc_en | output | 1 | Oscillator enable |
| div_en | output | 1 | Divider chain enable |
| update_pulse | output | 1 | One-second update pulse |
| uip | output | 1 | Update-in-progress bit |
| rate_sel | output | 4 | Periodic/square-wave rate select |
| sqw_en | output | 1 | Square-wave output enable |
| sq32k_en | output | 1 | Route 32.768 kHz clock to the square-wave pin |
| fmt_bin | output | 1 | Binary data format |
| fmt_24h | output | 1 | 24-hour format |
| dst_en | output | 1 | Daylight-saving adjustment enable |
| update_xfer_inhibit | output | 1 | Transfer inhibit to the time counters |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `periodic_evt` and `alarm_evt` are clean, synchronous pulses. They also assume that no write to register C coincides with a read of register C, because the write would then take priority over the read-clear that the alarm-flag property expects. The stimulus drives every bus access and every event between clock edges. Each access lasts exactly one cycle, and reads never overlap writes. Events are raised only while the divider is off, so the flags they leave are never mixed with update-flag setting.

// File: rtl/rtc_ctrl_pkg.sv
// Package: shared addresses, field positions and the decoded-mode type
// for the real-time clock control/status register bank.
package rtc_ctrl_pkg;

    localparam int          DATA_W    = 8;
    localparam logic [7:0]  ADDR_REGA = 8'h0A;
    localparam logic [7:0]  ADDR_REGB = 8'h0B;
    localparam logic [7:0]  ADDR_REGC = 8'h0C;
    localparam logic [7:0]  ADDR_REGD = 8'h0D;

    // Mode field encodings that the decoder distinguishes
    localparam logic [2:0]  MODE_RUN    = 3'b010;
    localparam logic [2:0]  MODE_RUN_CW = 3'b011;

    // Number of interrupt sources; index 2 periodic, 1 alarm, 0 update
    localparam int          NUM_SRC   = 3;

    typedef struct packed {
        logic osc_on;   // oscillator running
        logic div_on;   // divider chain running
        logic creg_wr;  // flag register writable
    } mode_dec_t;

endpackage

// File: rtl/rtc_mode_decode.sv
// Module: rtc_mode_decode
// Turns the three-bit mode field into oscillator, divider and
// flag-register-write enables. Purely combinational; assumes the field
// is held in a register by the caller.
module rtc_mode_decode
    import rtc_ctrl_pkg::*;
(
    input  logic [2:0] mode_field,
    output mode_dec_t  mode_dec
);

    // Decode each of the eight mode patterns
    always_comb begin
        mode_dec = '0;
        case (mode_field)
            MODE_RUN: begin
                mode_dec.osc_on = 1'b1;
                mode_dec.div_on = 1'b1;
            end
            MODE_RUN_CW: begin
                mode_dec.osc_on  = 1'b1;
                mode_dec.div_on  = 1'b1;
                mode_dec.creg_wr = 1'b1;
            end
            3'b110, 3'b111: begin
                mode_dec.osc_on = 1'b1;
            end
            default: mode_dec = '0;
        endcase
    end

endmodule

// File: rtl/rtc_update_timer.sv
// Module: rtc_update_timer
// Counts input clocks to place the one-second update pulse: the first
// pulse half a second after the divider is enabled, then one per second.
// Raises the update-in-progress bit LEAD_CYCLES cycles ahead of the pulse
// (the pulse cycle included). Assumes CLKS_PER_SEC >= 4 and
// 1 <= LEAD_CYCLES < CLKS_PER_SEC/2.
module rtc_update_timer #(
    parameter int CLKS_PER_SEC = 1000,
    parameter int LEAD_CYCLES  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic div_on,
    input  logic inhibit,
    output logic upd_pulse,
    output logic upd_busy
);

    localparam int CNT_W      = $clog2(CLKS_PER_SEC);
    localparam int HALF_SEC   = CLKS_PER_SEC / 2;
    localparam logic [CNT_W-1:0] RELOAD_FULL = CNT_W'(CLKS_PER_SEC - 1);
    localparam logic [CNT_W-1:0] RELOAD_HALF = CNT_W'(HALF_SEC - 1);
    localparam logic [CNT_W-1:0] LEAD_LIM    = CNT_W'(LEAD_CYCLES);

    logic [CNT_W-1:0] tick_cnt;
    logic             at_zero;

    assign at_zero = (tick_cnt == '0);

    // Countdown: held at the half-second preload while the divider is off
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt <= RELOAD_HALF;
        end else if (!div_on) begin
            tick_cnt <= RELOAD_HALF;
        end else if (at_zero) begin
            tick_cnt <= RELOAD_FULL;
        end else begin
            tick_cnt <= tick_cnt - 1'b1;
        end
    end

    // Pulse on the terminal count; busy in the lead window unless inhibited
    always_comb begin
        upd_pulse = div_on && at_zero;
        upd_busy  = div_on && !inhibit && (tick_cnt < LEAD_LIM);
    end

endmodule

// File: rtl/rtc_irq_flags.sv
// Module: rtc_irq_flags
// One sticky flag per interrupt source. Source event beats a software
// write, which beats the read-clear. The combined flag is the OR of
// each flag masked by its enable. Assumes events are one-cycle pulses.
module rtc_irq_flags #(
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_evt,
    input  logic [NSRC-1:0] src_en,
    input  logic            rd_clear,
    input  logic            sw_load,
    input  logic [NSRC-1:0] sw_val,
    output logic [NSRC-1:0] flag_q,
    output logic            any_flag
);

    for (genvar gi = 0; gi < NSRC; gi++) begin : g_flag
        // Per-source sticky flag with event priority
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q[gi] <= 1'b0;
            end else if (src_evt[gi]) begin
                flag_q[gi] <= 1'b1;
            end else if (sw_load) begin
                flag_q[gi] <= sw_val[gi];
            end else if (rd_clear) begin
                flag_q[gi] <= 1'b0;
            end
        end
    end

    // Masked OR of all flags
    always_comb any_flag = |(flag_q & src_en);

endmodule

// File: rtl/rtc_ctrl_regs.sv
// Module: rtc_ctrl_regs (top)
// Control/status register bank of a real-time clock on a synchronous
// byte bus. Holds the mode/rate register, the enable/format register,
// the flag register and the supply-status register; decodes the mode,
// times the update pulse and combines the interrupt flags. Assumes one
// access per cycle and single-cycle event pulses.
module rtc_ctrl_regs
    import rtc_ctrl_pkg::*;
#(
    parameter int CLKS_PER_SEC = 1000,
    parameter int LEAD_CYCLES  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              periodic_evt,
    input  logic              alarm_evt,
    input  logic              vrt_in,
    output logic              osc_en,
    output logic              div_en,
    output logic              update_pulse,
    output logic              uip,
    output logic [3:0]        rate_sel,
    output logic              sqw_en,
    output logic              sq32k_en,
    output logic              fmt_bin,
    output logic              fmt_24h,
    output logic              dst_en,
    output logic              update_xfer_inhibit,
    output logic              irq
);

    // Register A fields (not reset)
    logic [2:0] mode_q;
    logic [3:0] rate_q;
    // Register B fields: reset and non-reset groups
    logic       inh_q, dfmt_q, hfmt_q, dst_q;
    logic       pie_q, aie_q, uie_q, sqwe_q;
    // Register C 32 kHz enable (not reset)
    logic       k32_q;

    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;
    logic              wr_a, wr_b, wr_c, rd_c;
    mode_dec_t         mode_dec;
    logic [NUM_SRC-1:0] flag_q;
    logic              intf;
    logic              upd_pulse_w;
    logic              upd_busy_w;

    // Address decode of the bus strobes
    always_comb begin
        wr_a = bus_we && (bus_addr == ADDR_REGA);
        wr_b = bus_we && (bus_addr == ADDR_REGB);
        wr_c = bus_we && (bus_addr == ADDR_REGC) && mode_dec.creg_wr;
        rd_c = bus_re && (bus_addr == ADDR_REGC);
    end

    // Register A and the non-reset bits of B and C
    always_ff @(posedge clk) begin
        if (wr_a) begin
            mode_q <= bus_wdata[6:4];
            rate_q <= bus_wdata[3:0];
        end
        if (wr_b) begin
            inh_q  <= bus_wdata[7];
            dfmt_q <= bus_wdata[2];
            hfmt_q <= bus_wdata[1];
            dst_q  <= bus_wdata[0];
        end
        if (wr_c) begin
            k32_q <= bus_wdata[2];
        end
    end

    // Enable bits of register B, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pie_q  <= 1'b0;
            aie_q  <= 1'b0;
            uie_q  <= 1'b0;
            sqwe_q <= 1'b0;
        end else if (wr_b) begin
            pie_q  <= bus_wdata[6];
            aie_q  <= bus_wdata[5];
            uie_q  <= bus_wdata[4];
            sqwe_q <= bus_wdata[3];
        end
    end

    rtc_mode_decode u_mode (
        .mode_field (mode_q),
        .mode_dec   (mode_dec)
    );

    rtc_update_timer #(
        .CLKS_PER_SEC (CLKS_PER_SEC),
        .LEAD_CYCLES  (LEAD_CYCLES)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_on    (mode_dec.div_on),
        .inhibit   (inh_q),
        .upd_pulse (upd_pulse_w),
        .upd_busy  (upd_busy_w)
    );

    rtc_irq_flags #(
        .NSRC (NUM_SRC)
    ) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_evt  ({periodic_evt, alarm_evt, upd_pulse_w}),
        .src_en   ({pie_q, aie_q, uie_q}),
        .rd_clear (rd_c),
        .sw_load  (wr_c),
        .sw_val   (bus_wdata[6:4]),
        .flag_q   (flag_q),
        .any_flag (intf)
    );

    // Read multiplexer over the four registers
    always_comb begin
        case (bus_addr)
            ADDR_REGA: rd_mux = {upd_busy_w, mode_q, rate_q};
            ADDR_REGB: rd_mux = {inh_q, pie_q, aie_q, uie_q,
                                 sqwe_q, dfmt_q, hfmt_q, dst_q};
            ADDR_REGC: rd_mux = {intf, flag_q, 1'b0, k32_q, 2'b00};
            ADDR_REGD: rd_mux = {vrt_in, 7'b0};
            default:   rd_mux = '0;
        endcase
    end

    // Registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_re) begin
            rdata_q <= rd_mux;
        end
    end

    // Output assignments
    always_comb begin
        bus_rdata           = rdata_q;
        osc_en              = mode_dec.osc_on;
        div_en              = mode_dec.div_on;
        update_pulse        = upd_pulse_w;
        uip                 = upd_busy_w;
        rate_sel            = rate_q;
        sqw_en              = sqwe_q;
        sq32k_en            = k32_q && mode_dec.creg_wr;
        fmt_bin             = dfmt_q;
        fmt_24h             = hfmt_q;
        dst_en              = dst_q;
        update_xfer_inhibit = inh_q;
        irq                 = intf;
    end

endmodule

// File: rtl/rtc_ctrl_regs_chk.sv
// Module: rtc_ctrl_regs_chk
// Property checker bound into rtc_ctrl_regs. Assumes event inputs are
// synchronous pulses and that a write to register C never coincides
// with a read of it.
module rtc_ctrl_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] bus_addr,
    input logic       bus_we,
    input logic       bus_re,
    input logic       periodic_evt,
    input logic       alarm_evt,
    input logic       osc_en,
    input logic       div_en,
    input logic       update_pulse,
    input logic       uip,
    input logic       update_xfer_inhibit,
    input logic [2:0] flag_q,
    input logic       irq
);

    // R3: no update pulse unless the divider runs
    assert_pulse_needs_div_R3: assert property (@(posedge clk) disable iff (!rst_n)
        update_pulse |-> div_en);

    // R2: divider only runs with the oscillator on
    assert_div_needs_osc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        div_en |-> osc_en);

    // R4: busy bit is high in the pulse cycle when not inhibited
    assert_uip_at_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (update_pulse && !update_xfer_inhibit) |-> uip);

    // R5: inhibit forces the busy bit low
    assert_inhibit_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        update_xfer_inhibit |-> !uip);

    // R9: a periodic event leaves its flag set
    assert_periodic_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        periodic_evt |=> flag_q[2]);

    // R9: an update pulse leaves the update flag set
    assert_update_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        update_pulse |=> flag_q[0]);

    // R11: reading C without an alarm event clears the alarm flag
    assert_read_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr == 8'h0C && !bus_we && !alarm_evt) |=> !flag_q[1]);

    // R10: the interrupt request needs at least one flag
    assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag_q != 3'b000));

endmodule

bind rtc_ctrl_regs rtc_ctrl_regs_chk chk_i (
    .clk                 (clk),
    .rst_n               (rst_n),
    .bus_addr            (bus_addr),
    .bus_we              (bus_we),
    .bus_re              (bus_re),
    .periodic_evt        (periodic_evt),
    .alarm_evt           (alarm_evt),
    .osc_en              (osc_en),
    .div_en              (div_en),
    .update_pulse        (update_pulse),
    .uip                 (uip),
    .update_xfer_inhibit (update_xfer_inhibit),
    .flag_q              (flag_q),
    .irq                 (irq)
);

// File: tb/rtc_ctrl_regs_tb_top.sv
// Bench for rtc_ctrl_regs: vector table of write/readback pairs, then
// directed tests for reset, mode decode, update timing, flags and outputs.
module rtc_ctrl_regs_tb_top;

    localparam int SEC  = 1000;
    localparam int LEAD = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic       bus_re = 1'b0;
    logic [7:0] bus_rdata;
    logic       periodic_evt = 1'b0;
    logic       alarm_evt = 1'b0;
    logic       vrt_in = 1'b1;
    logic       osc_en, div_en, update_pulse, uip;
    logic [3:0] rate_sel;
    logic       sqw_en, sq32k_en, fmt_bin, fmt_24h, dst_en;
    logic       update_xfer_inhibit, irq;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;  // 250 MHz

    rtc_ctrl_regs #(.CLKS_PER_SEC(SEC), .LEAD_CYCLES(LEAD)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .periodic_evt(periodic_evt), .alarm_evt(alarm_evt), .vrt_in(vrt_in),
        .osc_en(osc_en), .div_en(div_en), .update_pulse(update_pulse),
        .uip(uip), .rate_sel(rate_sel), .sqw_en(sqw_en), .sq32k_en(sq32k_en),
        .fmt_bin(fmt_bin), .fmt_24h(fmt_24h), .dst_en(dst_en),
        .update_xfer_inhibit(update_xfer_inhibit), .irq(irq)
    );

    // {addr, write data, expected readback}
    localparam logic [23:0] VEC_TBL [0:10] = '{
        24'h0A_B3_33,  // R2 bit 7 ignored, mode 011
        24'h0B_A5_A5,  // R6
        24'h0C_74_F4,  // R8 R10 writable in 011, alarm flag+enable
        24'h0C_04_04,  // R8 flags written low
        24'h0C_00_00,  // R8
        24'h0A_E5_65,  // R2 mode 110
        24'h0C_74_00,  // R8 read-only outside 011
        24'h0B_00_00,  // R6
        24'h0D_FF_80,  // R12 write ignored, vrt_in=1
        24'h05_55_00,  // R1 unmapped
        24'h0A_F2_72   // R2
    };

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    // Step negedges until the update pulse; count cycles and busy cycles
    task automatic wait_pulse(output int n, output int nbusy);
        n = 0; nbusy = 0;
        do begin
            @(negedge clk);
            n++;
            if (uip && !update_pulse) nbusy++;
        end while (!update_pulse && n < 5000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL R3 watchdog actual=timeout expected=completion");
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] rv;
        int n, nb;
        logic exp_osc, exp_div;

        // Power-up reset state
        repeat (4) @(negedge clk);
        check(bus_rdata, 8'h00, "R7 rdata at reset");
        check(irq, 1'b0, "R10 irq at reset");
        check(update_pulse, 1'b0, "R3 no pulse in reset");
        rst_n = 1'b1;

        // Reset keeps non-reset bits, clears enables and flags
        wr(8'h0A, 8'h37);
        wr(8'h0C, 8'h74);
        wr(8'h0A, 8'h47);
        wr(8'h0B, 8'hFF);
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk); rst_n = 1'b1;
        rd(8'h0A, rv); check(rv, 8'h47, "R7 reg A kept");
        rd(8'h0B, rv); check(rv, 8'h87, "R7 reg B partial clear");
        rd(8'h0C, rv); check(rv, 8'h04, "R7 reg C flags cleared, 32k kept");

        // Vector table walk
        foreach (VEC_TBL[i]) begin
            wr(VEC_TBL[i][23:16], VEC_TBL[i][15:8]);
            rd(VEC_TBL[i][23:16], rv);
            check(rv, VEC_TBL[i][7:0], $sformatf("R1 vector %0d", i));
        end

        // Mode decode over all eight patterns
        for (int m = 0; m < 8; m++) begin
            wr(8'h0A, {1'b0, 3'(m), 4'h0});
            exp_div = (m == 2) || (m == 3);
            exp_osc = exp_div || (m >= 6);
            check(osc_en, exp_osc, $sformatf("R2 osc_en mode %0d", m));
            check(div_en, exp_div, $sformatf("R2 div_en mode %0d", m));
        end

        // Update timing: first after half a second, then every second
        wr(8'h0A, 8'h00);
        wr(8'h0B, 8'h10);
        wr(8'h0A, 8'h20);
        wait_pulse(n, nb);
        check(n, SEC/2 - 1, "R3 first update delay");
        check(nb, LEAD - 1, "R4 busy lead before first pulse");
        check(uip, 1'b1, "R4 busy in pulse cycle");
        @(negedge clk);
        check(irq, 1'b1, "R10 update irq");
        check(uip, 1'b0, "R4 busy low after pulse");
        wait_pulse(n, nb);
        check(n, SEC - 1, "R3 one-second period");
        check(nb, LEAD - 1, "R4 busy lead second pulse");
        rd(8'h0C, rv); check(rv, 8'h90, "R11 read C update flag");
        check(irq, 1'b0, "R11 irq cleared by read");

        // Inhibit holds busy low across a pulse
        wr(8'h0B, 8'h80);
        wait_pulse(n, nb);
        check(nb, 0, "R5 busy suppressed");
        check(uip, 1'b0, "R5 busy low at pulse");
        rd(8'h0A, rv); check(rv[7], 1'b0, "R5 reg A bit7 low");

        // Divider off: no pulse for over a second
        wr(8'h0A, 8'h60);
        n = 0;
        for (int k = 0; k < SEC + 20; k++) begin
            @(negedge clk);
            if (update_pulse) n++;
        end
        check(n, 0, "R3 no pulse with divider off");

        // Event flags, enables and read-clear race
        wr(8'h0B, 8'h40);
        rd(8'h0C, rv);
        @(negedge clk); periodic_evt = 1'b1;
        @(negedge clk); periodic_evt = 1'b0;
        check(irq, 1'b1, "R9 R10 periodic irq");
        @(negedge clk);
        bus_addr = 8'h0C; bus_re = 1'b1; alarm_evt = 1'b1;
        @(negedge clk);
        bus_re = 1'b0; alarm_evt = 1'b0;
        check(bus_rdata, 8'hC0, "R11 read returns pre-clear flags");
        check(irq, 1'b0, "R10 alarm flag without enable");
        rd(8'h0C, rv); check(rv, 8'h20, "R11 event wins over clear");
        rd(8'h0C, rv); check(rv, 8'h00, "R11 flags cleared");

        // Supply status bit
        vrt_in = 1'b0;
        rd(8'h0D, rv); check(rv, 8'h00, "R12 reg D follows vrt_in");

        // 32 kHz routing and register-B outputs
        wr(8'h0A, 8'h3C);
        wr(8'h0C, 8'h04);
        check(sq32k_en, 1'b1, "R13 32k on in mode 011");
        check(rate_sel, 4'hC, "R2 rate_sel");
        wr(8'h0A, 8'h20);
        check(sq32k_en, 1'b0, "R13 32k off in mode 010");
        wr(8'h0B, 8'h08);
        check(sqw_en, 1'b1, "R6 sqw_en");
        wr(8'h0B, 8'h87);
        check({update_xfer_inhibit, sqw_en, fmt_bin, fmt_24h, dst_en}, 5'b10111,
              "R6 format outputs");

        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule